// File: doc/BRIEF.md
# Serial Two-Wire Configuration Register Slave

This block is a two-wire serial bus slave that owns one 8-bit control byte for a power-and-signalling front end. A bus master writes six configuration bits into it and reads the whole byte back. The two low bits of the read byte are live status flags: a thermal flag and an overload flag. The six configuration bits leave the block as a parallel output and drive the rest of the front end.

The bus lines come in as raw SCL and SDA levels. They are synchronised to the system clock, and the block detects start, stop and clock edges from the synchronised levels. The slave answers one of four 7-bit addresses, chosen by two address-select inputs. It drives SDA only through an open-drain pull-down enable. While the supply-undervoltage input is high, the block clears the configuration byte and stays silent on the bus.

Top module: `i2c_sysreg_slave`

## Requirements
- R1: The slave address is the 7-bit value {00010, addr_sel_i[1], addr_sel_i[0]}, so it lies between 0x08 and 0x0B. Bit 0 of the first byte after a start is the direction bit, where 1 means read.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A start at any point abandons the byte in progress, commits nothing and begins address reception.
- R3: After reset, cfg_o is all zeros and sda_pd_o is 0.
- R4: When the address does not match, the slave gives no ACK, keeps SDA released and ignores every following byte until the next start or stop.
- R5: After a matching address byte, and after each data byte of a write, the slave pulls SDA low for the ninth clock. It asserts sda_pd_o only while SCL is low.
- R6: While uv_i is high, cfg_o is cleared to zero from the next clock on, sda_pd_o stays 0 and no byte is acknowledged. This holds even when uv_i rises in the same window in which a write byte would commit.
- R7: A written data byte sets cfg_o[5:0] to data bits 7 down to 2, and data bits 1 and 0 are discarded. Each data byte of a multi-byte write commits in turn, so the last one wins. cfg_o changes only while SCL is low.
- R8: The read byte is {cfg_o[5:0], status_i[1], status_i[0]}, sent MSB first: the thermal flag is at bit 1 and the overload flag at bit 0. The status flags are captured when the byte is loaded, on the SCL fall that ends the preceding ACK clock.
- R9: A master ACK (SDA low on the ninth clock) makes the slave send the byte again, with newly captured flags. A master NACK makes the slave release SDA and stay silent until the next start or stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 10 times the SCL rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw serial clock level from the pad |
| sda_i | input | 1 | Raw serial data level from the pad |
| addr_sel_i | input | 2 | Low two bits of the slave address |
| uv_i | input | 1 | Supply undervoltage flag, synchronous to clk_i |
| status_i | input | 2 | Live flags: [1] thermal, [0] overload |
| sda_pd_o | output | 1 | SDA open-drain pull-down enable |
| cfg_o | output | 6 | Configuration bits from the last accepted write |

## Verification
The undervoltage clear and the commit of a written data byte can fall in the same clock. Both act on the configuration byte and on the ACK pull-down. To provoke this, the bench raises uv_i at each offset from 0 to 5 system clocks after the eighth SCL fall of a data byte. One of these offsets lands on the commit edge. At every offset the reference model expects cfg_o to read zero and the ninth clock to carry no ACK. The commit must never appear afterwards, not even for a single cycle.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK,
    ST_SKIP
  } st_e;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  // bus idles high, so reset to 1
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain <= '1;
      else         chain <= {chain[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/i2cs_cond_det.sv
module i2cs_cond_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  assign start_o    = scl_s_i & scl_q & sda_q & ~sda_s_i;
  assign stop_o     = scl_s_i & scl_q & ~sda_q & sda_s_i;
  assign scl_rise_o = scl_s_i & ~scl_q;
  assign scl_fall_o = ~scl_s_i & scl_q;
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
#(
  parameter int unsigned CFG_W  = 6,
  parameter int unsigned SEL_W  = 2,
  parameter logic [6:0]  BASE_A = 7'h08
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  input  logic                        stop_i,
  input  logic                        scl_rise_i,
  input  logic                        scl_fall_i,
  input  logic                        sda_s_i,
  input  logic [SEL_W-1:0]            addr_sel_i,
  input  logic                        uv_i,
  input  logic [BYTE_W-CFG_W-1:0]     status_i,
  output logic                        sda_pd_o,
  output logic [CFG_W-1:0]            cfg_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

  st_e               state;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sh;
  logic [BYTE_W-2:0] tx;     // bits still to send after the one on the bus
  logic              rw;
  logic              mack;
  logic              pd;
  logic [CFG_W-1:0]  cfg;
  logic [6:0]        dev_a;
  logic [BYTE_W-1:0] rd_byte;

  assign dev_a   = {BASE_A[6:SEL_W], addr_sel_i};
  assign rd_byte = {cfg, status_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state <= ST_IDLE;
      cnt   <= '0;
      sh    <= '0;
      tx    <= '0;
      rw    <= 1'b0;
      mack  <= 1'b0;
      pd    <= 1'b0;
      cfg   <= '0;
    end else if (uv_i) begin
      state <= ST_IDLE;
      cnt   <= '0;
      pd    <= 1'b0;
      cfg   <= '0;
    end else if (start_i) begin
      state <= ST_ADDR;
      cnt   <= '0;
      pd    <= 1'b0;
    end else if (stop_i) begin
      state <= ST_IDLE;
      pd    <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR, ST_WDATA: begin
          if (scl_rise_i) begin
            sh  <= {sh[BYTE_W-2:0], sda_s_i};
            cnt <= cnt + 1'b1;
          end else if (scl_fall_i && cnt == CNT_FULL) begin
            if (state == ST_WDATA) begin
              cfg   <= sh[BYTE_W-1 -: CFG_W];
              pd    <= 1'b1;
              state <= ST_WACK;
            end else if (sh[BYTE_W-1:1] == dev_a) begin
              rw    <= sh[0];
              pd    <= 1'b1;
              state <= ST_AACK;
            end else begin
              state <= ST_SKIP;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall_i) begin
            cnt <= '0;
            if (rw) begin
              tx    <= rd_byte[BYTE_W-2:0];
              pd    <= ~rd_byte[BYTE_W-1];
              state <= ST_RDATA;
            end else begin
              pd    <= 1'b0;
              state <= ST_WDATA;
            end
          end
        end
        ST_WACK: begin
          if (scl_fall_i) begin
            cnt   <= '0;
            pd    <= 1'b0;
            state <= ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (scl_rise_i) begin
            cnt <= cnt + 1'b1;
          end else if (scl_fall_i) begin
            if (cnt == CNT_FULL) begin
              pd    <= 1'b0;
              state <= ST_RACK;
            end else begin
              pd <= ~tx[BYTE_W-2];
              tx <= {tx[BYTE_W-3:0], 1'b0};
            end
          end
        end
        ST_RACK: begin
          if (scl_rise_i) begin
            mack <= ~sda_s_i;
          end else if (scl_fall_i) begin
            if (mack) begin
              cnt   <= '0;
              tx    <= rd_byte[BYTE_W-2:0];
              pd    <= ~rd_byte[BYTE_W-1];
              state <= ST_RDATA;
            end else begin
              state <= ST_SKIP;
            end
          end
        end
        default: ;  // idle and skip wait for start or stop
      endcase
    end
  end

  assign sda_pd_o = pd;
  assign cfg_o    = cfg;
endmodule

// File: rtl/i2c_sysreg_slave.sv
module i2c_sysreg_slave
  import i2cs_pkg::*;
#(
  parameter int unsigned CFG_W  = 6,
  parameter int unsigned SEL_W  = 2,
  parameter logic [6:0]  BASE_A = 7'h08,
  parameter int unsigned STAGES = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    scl_i,
  input  logic                    sda_i,
  input  logic [SEL_W-1:0]        addr_sel_i,
  input  logic                    uv_i,
  input  logic [BYTE_W-CFG_W-1:0] status_i,
  output logic                    sda_pd_o,
  output logic [CFG_W-1:0]        cfg_o
);
  logic [1:0] bus_s;
  logic start, stop, scl_rise, scl_fall;

  i2cs_sync #(.WIDTH(2), .STAGES(STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   (bus_s)
  );

  i2cs_cond_det u_det (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_s_i   (bus_s[1]),
    .sda_s_i   (bus_s[0]),
    .start_o   (start),
    .stop_o    (stop),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall)
  );

  i2cs_engine #(.CFG_W(CFG_W), .SEL_W(SEL_W), .BASE_A(BASE_A)) u_eng (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .stop_i    (stop),
    .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall),
    .sda_s_i   (bus_s[0]),
    .addr_sel_i(addr_sel_i),
    .uv_i      (uv_i),
    .status_i  (status_i),
    .sda_pd_o  (sda_pd_o),
    .cfg_o     (cfg_o)
  );
endmodule

// File: rtl/i2c_sysreg_slave_chk.sv
module i2c_sysreg_slave_chk #(
  parameter int unsigned CFG_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             scl_i,
  input logic             uv_i,
  input logic             sda_pd_o,
  input logic [CFG_W-1:0] cfg_o
);
  p_uv_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uv_i |=> (cfg_o == '0));

  p_uv_no_ack_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uv_i |=> !sda_pd_o);

  p_cfg_scl_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(cfg_o) && !$past(uv_i)) |-> !scl_i);

  p_pd_rise_scl_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_pd_o) |-> (!scl_i && !$past(uv_i)));
endmodule

bind i2c_sysreg_slave i2c_sysreg_slave_chk #(.CFG_W(CFG_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .scl_i   (scl_i),
  .uv_i    (uv_i),
  .sda_pd_o(sda_pd_o),
  .cfg_o   (cfg_o)
);

// File: tb/sim_i2c_sysreg_slave.sv
`timescale 1ns/1ps
module sim_i2c_sysreg_slave;
  localparam int Q = 100;  // quarter SCL period, 10 system clocks

  logic       clk = 1'b0;
  logic       rst_n;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic [1:0] addr_sel = 2'd0;
  logic       uv = 1'b0;
  logic [1:0] status = 2'b00;
  logic       sda_pd;
  logic [5:0] cfg;
  logic       sda_bus;

  int n_chk = 0, n_err = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;
  logic [5:0] exp_cfg = 6'h00;
  logic [7:0] exp_q[$];

  assign sda_bus = sda_m & ~sda_pd;

  always #5 clk = ~clk;

  i2c_sysreg_slave u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .addr_sel_i(addr_sel), .uv_i(uv), .status_i(status),
    .sda_pd_o(sda_pd), .cfg_o(cfg)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // reference model: configuration byte compared on every clock
  always @(negedge clk) begin
    if (rst_n === 1'b1 && cmp_en)
      check(cfg === exp_cfg, "R7 per-clock cfg_o", int'(cfg), int'(exp_cfg));
  end

  task automatic bit_clk(input bit b, input int uv_off, output bit rd);
    sda_m = b;
    #Q; scl = 1'b1;
    #Q; rd = sda_bus;
    #Q; scl = 1'b0;
    if (uv_off >= 0) begin
      #(uv_off * 10);
      uv = 1'b1;
      exp_cfg = 6'h00;
      #(Q - uv_off * 10);
    end else begin
      #Q;
    end
  endtask

  task automatic do_start();
    sda_m = 1'b1; #Q; scl = 1'b1; #Q; sda_m = 1'b0; #Q; scl = 1'b0; #Q;
  endtask

  task automatic do_stop();
    sda_m = 1'b0; #Q; scl = 1'b1; #Q; sda_m = 1'b1; #Q;
  endtask

  task automatic send_byte(input logic [7:0] b, input int uv_off, output bit acked);
    bit r;
    for (int i = 7; i >= 0; i--) bit_clk(b[i], (i == 0) ? uv_off : -1, r);
    bit_clk(1'b1, -1, r);
    acked = ~r;
  endtask

  task automatic recv_byte(input bit m_ack, output logic [7:0] b);
    bit r;
    for (int i = 7; i >= 0; i--) begin
      bit_clk(1'b1, -1, r);
      b[i] = r;
    end
    bit_clk(~m_ack, -1, r);
  endtask

  // write of data bytes to a matching address, model updated after commit
  task automatic write_cfg(input logic [7:0] a, input logic [7:0] d, input string req);
    bit ak;
    do_start();
    send_byte(a, -1, ak);
    check(ak, "R5 address ACK", ak, 1);
    cmp_en = 1'b0;
    send_byte(d, -1, ak);
    exp_cfg = d[7:2];
    cmp_en = 1'b1;
    check(ak, "R5 data ACK", ak, 1);
    check(cfg === d[7:2], req, int'(cfg), int'(d[7:2]));
    do_stop();
  endtask

  initial begin
    logic [7:0] rb;
    bit ak;
    rst_n = 1'b0;
    #2;
    #40;
    check(cfg === 6'h00, "R3 reset cfg_o", int'(cfg), 0);
    check(sda_pd === 1'b0, "R3 reset sda_pd_o", int'(sda_pd), 0);
    #10 rst_n = 1'b1;
    #100;
    cmp_en = 1'b1;

    // R7: masking of the two low bits
    write_cfg(8'h10, 8'hFF, "R7 write 0xFF");
    write_cfg(8'h10, 8'h03, "R7 low bits discarded");
    write_cfg(8'h10, 8'hB4, "R7 write 0xB4");

    // R8/R9: read, repeat on ACK with new flags, silence after NACK
    status = 2'b10;
    do_start();
    send_byte(8'h11, -1, ak);
    check(ak, "R1 read address ACK", ak, 1);
    exp_q.push_back({exp_cfg, 2'b10});
    status = 2'b01;
    exp_q.push_back({exp_cfg, 2'b01});
    recv_byte(1'b1, rb);
    check(rb === exp_q[0], "R8 first read byte", int'(rb), int'(exp_q[0]));
    recv_byte(1'b0, rb);
    check(rb === exp_q[1], "R9 repeated byte new flags", int'(rb), int'(exp_q[1]));
    exp_q.delete();
    recv_byte(1'b0, rb);
    check(rb === 8'hFF, "R9 silent after NACK", int'(rb), 8'hFF);
    do_stop();

    // R7: multi-byte write, last wins
    do_start();
    send_byte(8'h10, -1, ak);
    cmp_en = 1'b0;
    send_byte(8'h80, -1, ak);
    exp_cfg = 6'h20; cmp_en = 1'b1;
    check(ak && cfg === 6'h20, "R7 multi-byte first", int'(cfg), 6'h20);
    cmp_en = 1'b0;
    send_byte(8'h0C, -1, ak);
    exp_cfg = 6'h03; cmp_en = 1'b1;
    check(ak && cfg === 6'h03, "R7 multi-byte last wins", int'(cfg), 6'h03);
    do_stop();

    // R4: address mismatch
    do_start();
    send_byte(8'h12, -1, ak);
    check(!ak, "R4 mismatch no ACK", ak, 0);
    send_byte(8'h00, -1, ak);
    check(!ak, "R4 following byte ignored", ak, 0);
    check(cfg === exp_cfg, "R4 cfg unchanged", int'(cfg), int'(exp_cfg));
    do_stop();

    // R1: select 3 moves the address to 0x0B
    addr_sel = 2'd3;
    #100;
    do_start();
    send_byte(8'h10, -1, ak);
    check(!ak, "R1 old address ignored", ak, 0);
    do_stop();
    write_cfg(8'h16, 8'h5C, "R1 address 0x0B write");
    addr_sel = 2'd0;
    #100;

    // R2: start inside a data byte aborts it
    do_start();
    send_byte(8'h10, -1, ak);
    for (int i = 0; i < 4; i++) bit_clk(1'b0, -1, ak);
    do_start();
    check(cfg === exp_cfg, "R2 aborted byte not committed", int'(cfg), int'(exp_cfg));
    send_byte(8'h10, -1, ak);
    check(ak, "R2 address after repeated start", ak, 1);
    cmp_en = 1'b0;
    send_byte(8'hA4, -1, ak);
    exp_cfg = 6'h29; cmp_en = 1'b1;
    check(cfg === 6'h29, "R2 write after repeated start", int'(cfg), 6'h29);
    do_stop();

    // R6: undervoltage raised around the commit edge
    for (int off = 0; off <= 5; off++) begin
      write_cfg(8'h10, 8'hFC, "R7 preload");
      do_start();
      send_byte(8'h10, -1, ak);
      cmp_en = 1'b0;
      send_byte(8'h54, off, ak);
      cmp_en = 1'b1;
      check(!ak, "R6 no ACK when uv meets commit", ak, 0);
      check(cfg === 6'h00, "R6 cfg cleared when uv meets commit", int'(cfg), 0);
      do_stop();
      do_start();
      send_byte(8'h10, -1, ak);
      check(!ak, "R6 address ignored under uv", ak, 0);
      do_stop();
      uv = 1'b0;
      #100;
    end
    write_cfg(8'h10, 8'h28, "R6 write after uv clears");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule